// File: doc/BRIEF.md
# TX Command-Word Packet Assembler

This block sits behind a transmit data port that software fills one 32-bit word per write. Every buffer segment opens with two command words. The first word gives the byte count, the start offset, the end alignment and the flags for first segment, last segment and completion interrupt. The second word carries a 16-bit packet tag. The data words that follow are parsed by a small state machine. It skips the leading offset bytes, passes payload bytes in little-endian lane order, and discards whole padding words at the end of the segment.

Payload leaves the block as the written word plus a lane mask that marks which bytes belong to the frame. When a segment flagged as last completes, the block pulses a frame-done strobe with the assembled byte count and pushes the tag into a status FIFO that software pops. The block also raises one-cycle event strobes for segment completion, for the status FIFO becoming full, and for data-port overflow. A write counter bounds the data port, and its limit is supplied as an input.

Top module: `txcmd_assembler`

## Requirements
- R1: After reset, `out_valid`, `frame_done`, `ioc_evt`, `stat_full_evt` and `ovf_evt` are low and `stat_level` is 0.
- R2: When the parser is idle, a write is taken as command A and the next write as command B; the writes after that are data words. Only bits 31, 25:24, 20:16, 13, 12 and 10:0 of command A have any effect, and command words never produce payload output.
- R3: The payload byte count is command A bits 10:0 and the start offset is bits 20:16. Offset bytes are skipped, and an offset of 4 or more consumes whole data words. Payload is taken lane 0 (bits 7:0) first, and `out_keep` marks the kept lanes one cycle after the write.
- R4: Command A bits 25:24 choose end alignment: 1 pads the data-word count of the segment (offset words included) to a multiple of 4, 2 pads it to a multiple of 8, and 0 or 3 add no padding. Pad words produce no output.
- R5: Command A bit 13 (first segment) restarts the frame byte count at zero. A segment without this bit appends to the frame.
- R6: One cycle after the final word of a segment whose bit 12 (last) is set, `frame_done` pulses for one cycle and `frame_bytes` holds the frame length. After any segment ends, the next write is taken as command A.
- R7: Each completed frame pushes `{tag, 16'h0}` into the status FIFO, where the tag is command B bits 31:16. `stat_data` shows the oldest entry, `stat_pop` removes it, and a pop while the FIFO is empty has no effect.
- R8: A push that brings `stat_level` to `STAT_DEPTH` pulses `stat_full_evt` for one cycle. A push while the FIFO is full is dropped.
- R9: Every write, command or data, counts toward a word counter that clears when a frame completes. A write arriving while the counter equals `data_limit` is discarded, pulses `ovf_evt`, and leaves the parser state unchanged.
- R10: If command A bit 31 is set, `ioc_evt` pulses one cycle after the final word of that segment.
- R11: Bytes past `MAX_BYTES` in a frame are dropped from `out_keep`, and `frame_bytes` saturates at `MAX_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the data port |
| wr_data | input | 32 | Word written to the data port |
| data_limit | input | LIMIT_W | Word capacity of the data port |
| out_valid | output | 1 | At least one payload lane is valid |
| out_data | output | 32 | Written word, one byte per lane |
| out_keep | output | 4 | Payload lane mask, bit n covers bits 8n+7:8n |
| frame_done | output | 1 | Frame completed (one-cycle pulse) |
| frame_bytes | output | $clog2(MAX_BYTES+1) | Length of the completed frame |
| stat_pop | input | 1 | Remove the oldest status entry |
| stat_data | output | 32 | Oldest status entry |
| stat_level | output | $clog2(STAT_DEPTH)+1 | Status FIFO occupancy |
| ioc_evt | output | 1 | Segment completion event |
| stat_full_evt | output | 1 | Status FIFO became full |
| ovf_evt | output | 1 | Data write discarded on overflow |

## Verification
The bench builds the block with `MAX_BYTES` = 64 and `STAT_DEPTH` = 8. With these values, multi-segment random frames run into the length cap, and a run of nine frames with no pops fills the status FIFO and then drops a push. `data_limit` is driven low during one frame so that a write is discarded mid-segment, then raised again so that the same frame can complete. Random segments combine offsets past one word with every alignment code and with junk in the unused command bits.

// File: rtl/txa_pkg.sv
package txa_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMDB, ST_DATA} txa_state_e;

  localparam logic [31:0] TXA_CMDA_MASK = 32'h831F_37FF;

  typedef struct packed {
    logic        ioc;
    logic [1:0]  align;
    logic [4:0]  off;
    logic        first;
    logic        last;
    logic [10:0] size;
  } txa_cmda_t;

  function automatic txa_cmda_t txa_decode_a(input logic [31:0] w);
    logic [31:0] m;
    txa_cmda_t c;
    m       = w & TXA_CMDA_MASK;
    c.ioc   = m[31];
    c.align = m[25:24];
    c.off   = m[20:16];
    c.first = m[13];
    c.last  = m[12];
    c.size  = m[10:0];
    return c;
  endfunction
endpackage

// File: rtl/txa_lane_sel.sv
module txa_lane_sel #(
  parameter int MAX_BYTES = 2048,
  parameter int LEN_W     = 12
) (
  input  logic [4:0]       off,
  input  logic [10:0]      size,
  input  logic [LEN_W-1:0] flen,
  output logic [3:0]       keep,
  output logic [2:0]       ntake,
  output logic [2:0]       nkeep
);
  localparam int PW = LEN_W + 2;

  logic [3:0]  take;
  logic [11:0] span_end;
  assign span_end = 12'(off) + 12'(size);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [PW-1:0] pos;
    assign take[g] = (5'(g) >= off) && (12'(g) < span_end);
    assign pos     = PW'(flen) + PW'(g) - PW'(off);
    assign keep[g] = take[g] && (pos < PW'(MAX_BYTES));
  end

  always_comb begin
    ntake = '0;
    nkeep = '0;
    for (int i = 0; i < 4; i++) begin
      ntake = ntake + 3'(take[i]);
      nkeep = nkeep + 3'(keep[i]);
    end
  end
endmodule

// File: rtl/txa_parser.sv
module txa_parser
  import txa_pkg::*;
#(
  parameter int MAX_BYTES = 2048,
  parameter int LEN_W     = 12,
  parameter int LIMIT_W   = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic [LIMIT_W-1:0] data_limit,
  output logic               out_valid,
  output logic [31:0]        out_data,
  output logic [3:0]         out_keep,
  output logic               frame_done,
  output logic [LEN_W-1:0]   frame_bytes,
  output logic               ioc_evt,
  output logic               ovf_evt,
  output logic               push_en,
  output logic [15:0]        push_tag
);
  txa_state_e         state_q, state_d;
  logic [10:0]        size_q, size_d;
  logic [4:0]         off_q, off_d;
  logic [2:0]         pad_q, pad_d;
  logic [1:0]         align_q, align_d;
  logic               last_q, last_d, ioc_q, ioc_d;
  logic [15:0]        tag_q, tag_d;
  logic [LEN_W-1:0]   flen_q, flen_d, fbytes_q, fbytes_d;
  logic [LIMIT_W-1:0] used_q, used_d;
  logic               vld_q, vld_d, done_q, done_d, ioce_q, ioce_d, ovf_q, ovf_d;
  logic [3:0]         keep_q, keep_d;
  logic [31:0]        data_q;
  logic               accept;
  logic [12:0]        nwords, negw;
  logic [3:0]         lane_keep;
  logic [2:0]         ntake, nkeep;
  txa_cmda_t          cmd;

  txa_lane_sel #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_lanes (
    .off(off_q), .size(size_q), .flen(flen_q),
    .keep(lane_keep), .ntake(ntake), .nkeep(nkeep)
  );

  always_comb begin
    state_d = state_q;  size_d = size_q;   off_d = off_q;   pad_d = pad_q;
    align_d = align_q;  last_d = last_q;   ioc_d = ioc_q;   tag_d = tag_q;
    flen_d  = flen_q;   used_d = used_q;   fbytes_d = fbytes_q;
    vld_d   = 1'b0;     keep_d = '0;       done_d = 1'b0;   ioce_d = 1'b0;
    push_en = 1'b0;
    cmd     = txa_decode_a(wr_data);
    accept  = wr_en && (used_q != data_limit);
    ovf_d   = wr_en && !accept;
    nwords  = (13'(size_q) + 13'(off_q) + 13'd3) >> 2;
    negw    = 13'd0 - nwords;
    if (accept) begin
      used_d = used_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          size_d  = cmd.size;  off_d = cmd.off;  align_d = cmd.align;
          last_d  = cmd.last;  ioc_d = cmd.ioc;
          if (cmd.first) flen_d = '0;
          state_d = ST_CMDB;
        end
        ST_CMDB: begin
          tag_d = wr_data[31:16];
          case (align_q)
            2'd1:    pad_d = {1'b0, negw[1:0]};
            2'd2:    pad_d = negw[2:0];
            default: pad_d = 3'd0;
          endcase
          state_d = ST_DATA;
        end
        ST_DATA: begin
          if (off_q >= 5'd4) begin
            off_d = off_q - 5'd4;
          end else if (size_q == 11'd0) begin
            if (pad_q != 3'd0) pad_d = pad_q - 3'd1;
          end else begin
            size_d = size_q - 11'(ntake);
            off_d  = 5'd0;
            flen_d = flen_q + LEN_W'(nkeep);
            keep_d = lane_keep;
            vld_d  = |lane_keep;
          end
          if (size_d == 11'd0 && pad_d == 3'd0) begin
            state_d = ST_IDLE;
            ioce_d  = ioc_q;
            if (last_q) begin
              done_d   = 1'b1;
              fbytes_d = flen_d;
              push_en  = 1'b1;
              used_d   = '0;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  size_q <= '0;  off_q <= '0;  pad_q <= '0;
      align_q <= '0;  last_q <= 1'b0;  ioc_q <= 1'b0;  tag_q <= '0;
      flen_q  <= '0;  used_q <= '0;  fbytes_q <= '0;  data_q <= '0;
      vld_q   <= 1'b0;  keep_q <= '0;  done_q <= 1'b0;
      ioce_q  <= 1'b0;  ovf_q <= 1'b0;
    end else begin
      if (wr_en) begin
        state_q <= state_d;  size_q <= size_d;  off_q <= off_d;  pad_q <= pad_d;
        align_q <= align_d;  last_q <= last_d;  ioc_q <= ioc_d;  tag_q <= tag_d;
        flen_q  <= flen_d;   used_q <= used_d;  data_q <= wr_data;
      end
      fbytes_q <= fbytes_d;
      vld_q    <= vld_d;   keep_q <= keep_d;  done_q <= done_d;
      ioce_q   <= ioce_d;  ovf_q  <= ovf_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_data    = data_q;
  assign out_keep    = keep_q;
  assign frame_done  = done_q;
  assign frame_bytes = fbytes_q;
  assign ioc_evt     = ioce_q;
  assign ovf_evt     = ovf_q;
  assign push_tag    = tag_q;
endmodule

// File: rtl/txa_stat_fifo.sv
module txa_stat_fifo #(
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [15:0]   push_tag,
  input  logic          pop,
  output logic [31:0]   head_data,
  output logic [$clog2(DEPTH):0] level,
  output logic          full_evt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop, fevt_q, fevt_d;

  always_comb begin
    do_push = push_en && (cnt_q != CW'(DEPTH));
    do_pop  = pop && (cnt_q != '0);
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    fevt_d = do_push && !do_pop && (cnt_q == CW'(DEPTH - 1));
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;  rd_q <= '0;  cnt_q <= '0;  fevt_q <= 1'b0;
    end else begin
      wr_q <= wr_d;  rd_q <= rd_d;  cnt_q <= cnt_d;  fevt_q <= fevt_d;
    end
  end

  assign head_data = {mem[rd_q], 16'h0000};
  assign level     = cnt_q;
  assign full_evt  = fevt_q;
endmodule

// File: rtl/txa_rst_sync.sv
module txa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/txcmd_assembler.sv
module txcmd_assembler #(
  parameter int MAX_BYTES  = 2048,
  parameter int STAT_DEPTH = 512,
  parameter int LIMIT_W    = 13,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int SCW       = $clog2(STAT_DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic [LIMIT_W-1:0] data_limit,
  output logic               out_valid,
  output logic [31:0]        out_data,
  output logic [3:0]         out_keep,
  output logic               frame_done,
  output logic [LEN_W-1:0]   frame_bytes,
  input  logic               stat_pop,
  output logic [31:0]        stat_data,
  output logic [SCW-1:0]     stat_level,
  output logic               ioc_evt,
  output logic               stat_full_evt,
  output logic               ovf_evt
);
  logic        rst_sync_n;
  logic        push_en;
  logic [15:0] push_tag;

  txa_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  txa_parser #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .LIMIT_W(LIMIT_W)) u_parse (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
    .data_limit(data_limit), .out_valid(out_valid), .out_data(out_data),
    .out_keep(out_keep), .frame_done(frame_done), .frame_bytes(frame_bytes),
    .ioc_evt(ioc_evt), .ovf_evt(ovf_evt), .push_en(push_en), .push_tag(push_tag)
  );

  txa_stat_fifo #(.DEPTH(STAT_DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_sync_n), .push_en(push_en), .push_tag(push_tag),
    .pop(stat_pop), .head_data(stat_data), .level(stat_level),
    .full_evt(stat_full_evt)
  );
endmodule

// File: rtl/txa_checker.sv
module txa_checker #(
  parameter int MAX_BYTES  = 2048,
  parameter int STAT_DEPTH = 512,
  parameter int LEN_W      = 12,
  parameter int SCW        = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             out_valid,
  input logic             frame_done,
  input logic [LEN_W-1:0] frame_bytes,
  input logic             stat_pop,
  input logic [SCW-1:0]   stat_level,
  input logic             stat_full_evt,
  input logic             ovf_evt
);
  // R9
  ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> !out_valid && !frame_done);

  // R11
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_bytes <= LEN_W'(MAX_BYTES));

  // R6
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(wr_en));

  // R8
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_full_evt |-> stat_level == SCW'(STAT_DEPTH));

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_level <= SCW'(STAT_DEPTH));

  // R7
  push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !$past(stat_pop) && ($past(stat_level) < SCW'(STAT_DEPTH))
    |-> stat_level == $past(stat_level) + 1'b1);

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat_pop) && ($past(stat_level) == '0) && !frame_done
    |-> stat_level == '0);
endmodule

bind txcmd_assembler txa_checker #(
  .MAX_BYTES(MAX_BYTES), .STAT_DEPTH(STAT_DEPTH), .LEN_W(LEN_W), .SCW(SCW)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .out_valid(out_valid),
  .frame_done(frame_done), .frame_bytes(frame_bytes), .stat_pop(stat_pop),
  .stat_level(stat_level), .stat_full_evt(stat_full_evt), .ovf_evt(ovf_evt)
);

// File: tb/txcmd_assembler_test.sv
`timescale 1ns/1ps
module txcmd_assembler_test;
  localparam int MAXB = 64;
  localparam int SDEP = 8;
  localparam int LW   = 13;
  localparam int LENW = $clog2(MAXB + 1);
  localparam int SCW  = $clog2(SDEP) + 1;
  localparam logic [31:0] AMASK = 32'h831F_37FF;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [31:0]     wr_data;
  logic [LW-1:0]   data_limit;
  logic            out_valid;
  logic [31:0]     out_data;
  logic [3:0]      out_keep;
  logic            frame_done;
  logic [LENW-1:0] frame_bytes;
  logic            stat_pop;
  logic [31:0]     stat_data;
  logic [SCW-1:0]  stat_level;
  logic            ioc_evt, stat_full_evt, ovf_evt;

  txcmd_assembler #(.MAX_BYTES(MAXB), .STAT_DEPTH(SDEP), .LIMIT_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .data_limit(data_limit), .out_valid(out_valid), .out_data(out_data),
    .out_keep(out_keep), .frame_done(frame_done), .frame_bytes(frame_bytes),
    .stat_pop(stat_pop), .stat_data(stat_data), .stat_level(stat_level),
    .ioc_evt(ioc_evt), .stat_full_evt(stat_full_evt), .ovf_evt(ovf_evt)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [7:0]  rxbuf [256];
  logic [7:0]  expbuf[256];
  int          rx_n, exp_n;
  logic [7:0]  pb = 8'h10;
  logic [15:0] tq[$];
  logic        g_valid, g_done, g_ioc, g_ovf, g_full;
  int          g_bytes;

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(posedge clk); #1;
    wr_en = 1'b0;
    g_valid = out_valid; g_done = frame_done; g_bytes = int'(frame_bytes);
    g_ioc = ioc_evt; g_ovf = ovf_evt; g_full = stat_full_evt;
    if (out_valid)
      for (int l = 0; l < 4; l++)
        if (out_keep[l] && rx_n < 256) begin
          rxbuf[rx_n] = out_data[8*l +: 8];
          rx_n++;
        end
  endtask

  task automatic mk_word(input int w, input int off, input int size, output logic [31:0] word);
    for (int l = 0; l < 4; l++) begin
      int p = 4*w + l;
      logic [7:0] b;
      if (p >= off && p < off + size) begin
        b = pb; pb = pb + 8'd1;
        if (exp_n < 256) expbuf[exp_n] = b;
        exp_n++;
      end else b = 8'($urandom);
      word[8*l +: 8] = b;
    end
  endtask

  task automatic cmp_bytes(input string req);
    int m = 0;
    int lim = imin(exp_n, MAXB);
    check(req, rx_n, lim);
    for (int i = 0; i < lim && i < rx_n; i++) if (rxbuf[i] !== expbuf[i]) m++;
    check(req, m, 0);
  endtask

  task automatic frame_end_status(input logic [15:0] tag);
    int pushed = 0;
    if (tq.size() < SDEP) begin tq.push_back(tag); pushed = 1; end
    check("R8 full event", int'(g_full), (pushed == 1 && tq.size() == SDEP) ? 1 : 0);
    check("R7 level after push", int'(stat_level), tq.size());
  endtask

  task automatic seg(input int size, input int off, input int align, input bit first,
                     input bit last, input bit ioc, input logic [15:0] tag);
    logic [31:0] a, word;
    int n, mult, nw, early_done, early_ioc, pad_out, cmd_out;
    a = ({31'd0, ioc} << 31) | (32'(align) << 24) | (32'(off) << 16) |
        ({31'd0, first} << 13) | ({31'd0, last} << 12) | 32'(size) |
        ($urandom & ~AMASK);
    if (first) begin exp_n = 0; rx_n = 0; end
    early_done = 0; early_ioc = 0; pad_out = 0; cmd_out = 0;
    wr(a);
    cmd_out += int'(g_valid); early_done += int'(g_done); early_ioc += int'(g_ioc);
    wr({tag, 16'($urandom)});
    cmd_out += int'(g_valid); early_done += int'(g_done); early_ioc += int'(g_ioc);
    check("R2 command words give no output", cmd_out, 0);
    n    = (size + off + 3) / 4;
    mult = (align == 1) ? 4 : (align == 2) ? 8 : 1;
    nw   = ((n + mult - 1) / mult) * mult;
    for (int w = 0; w < nw; w++) begin
      mk_word(w, off, size, word);
      wr(word);
      if (w >= n) pad_out += int'(g_valid);
      if (w < nw - 1) begin
        early_done += int'(g_done);
        early_ioc  += int'(g_ioc);
      end
    end
    check("R4 pad words silent", pad_out, 0);
    check("R10 ioc early", early_ioc, 0);
    check("R10 ioc at segment end", int'(g_ioc), int'(ioc));
    check("R6 done early", early_done, 0);
    check("R6 done at last segment", int'(g_done), int'(last));
    if (last) begin
      check("R6 R11 frame_bytes", g_bytes, imin(exp_n, MAXB));
      cmp_bytes("R3 payload bytes");
      frame_end_status(tag);
    end
  endtask

  task automatic pop_check();
    @(negedge clk);
    if (tq.size() > 0) check("R7 stat_data head", int'(stat_data), int'({tq[0], 16'h0000}));
    stat_pop = 1'b1;
    @(posedge clk); #1;
    stat_pop = 1'b0;
    if (tq.size() > 0) void'(tq.pop_front());
    check("R7 level after pop", int'(stat_level), tq.size());
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; stat_pop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    tq.delete();
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 frame_done", int'(frame_done), 0);
    check("R1 stat_level", int'(stat_level), 0);
    check("R1 events", int'({ioc_evt, stat_full_evt, ovf_evt}), 0);
  endtask

  initial begin
    #(100000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] word;
    void'($urandom(32'd7741));
    data_limit = 13'd1000;
    rx_n = 0; exp_n = 0;
    do_reset();

    // R3 basic frame, aligned, no offset
    seg(4, 0, 0, 1, 1, 1, 16'hA001);
    pop_check();
    // R3 offset past one word, R4 16-byte alignment
    seg(7, 6, 1, 1, 1, 0, 16'hA002);
    pop_check();
    // R4 32-byte alignment, code 3 no padding
    seg(5, 1, 2, 1, 1, 0, 16'hA003);
    seg(9, 2, 3, 1, 1, 1, 16'hA004);
    pop_check(); pop_check();
    // R5 first bit restarts length
    seg(5, 0, 0, 1, 0, 1, 16'h0000);
    seg(3, 1, 0, 1, 1, 0, 16'hA005);
    check("R5 restart length", g_bytes, 3);
    pop_check();
    // R5 append without first bit
    seg(10, 3, 0, 1, 0, 0, 16'h0000);
    seg(12, 0, 1, 0, 1, 0, 16'hA006);
    check("R5 appended length", g_bytes, 22);
    pop_check();
    // R11 length cap
    seg(40, 0, 0, 1, 0, 0, 16'h0000);
    seg(40, 2, 0, 0, 1, 1, 16'hA007);
    check("R11 capped length", g_bytes, MAXB);
    pop_check();

    // R2 R3 R4 random segments
    for (int f = 0; f < 25; f++) begin
      int ns = 1 + int'($urandom % 3);
      for (int s = 0; s < ns; s++)
        seg(1 + int'($urandom % 24), int'($urandom % 10), int'($urandom % 4),
            s == 0, s == ns - 1, 1'($urandom), 16'($urandom));
      pop_check();
    end

    // R8 fill status FIFO, then one dropped push
    for (int f = 0; f < SDEP + 1; f++) seg(2, 0, 0, 1, 1, 0, 16'(16'hB000 + f));
    check("R8 level stays full", int'(stat_level), SDEP);
    for (int f = 0; f < SDEP; f++) pop_check();
    check("R8 dropped tag absent", tq.size(), 0);
    // R7 pop while empty
    pop_check();
    check("R7 empty pop level", int'(stat_level), 0);

    // R9 overflow discards a word mid-segment
    data_limit = 13'd6;
    exp_n = 0; rx_n = 0;
    wr(32'h0000_3000 | 32'd40);
    wr({16'hC001, 16'h0});
    for (int w = 0; w < 4; w++) begin
      mk_word(w, 0, 40, word); wr(word);
      check("R9 no overflow below limit", int'(g_ovf), 0);
    end
    wr(32'hEEEE_EEEE);
    check("R9 overflow event", int'(g_ovf), 1);
    check("R9 discarded word no output", int'(g_valid), 0);
    data_limit = 13'd1000;
    for (int w = 4; w < 10; w++) begin mk_word(w, 0, 40, word); wr(word); end
    check("R9 frame completes", int'(g_done), 1);
    check("R9 frame_bytes", g_bytes, 40);
    cmp_bytes("R9 payload without dropped word");
    frame_end_status(16'hC001);
    pop_check();
    // R9 counter clears on frame completion
    data_limit = 13'd2;
    wr(32'h0000_3008);
    check("R9 counter cleared", int'(g_ovf), 0);
    wr({16'hC002, 16'h0});
    check("R9 counter cleared", int'(g_ovf), 0);
    wr(32'h1234_5678);
    check("R9 overflow at limit", int'(g_ovf), 1);

    data_limit = 13'd1000;
    do_reset();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule